// File: doc/BRIEF.md
# SRAM Tile Power Sequencer

This block manages the power switches of a bank of independently controlled SRAM tiles that sit inside one parent power domain. Every tile has two switches: one feeds the storage array and one feeds the peripheral circuitry (decoders, sense amplifiers, I/O). Software or a power manager asks for one of three modes per tile: Off, Retention or On. The block drives the two switches in a safe order and reports each tile's settled mode. It also reports a busy flag while a tile is between modes.

The request port is a valid/ready stream carrying a tile index and a target mode. Back-pressure rule: `req_ready` is low while the addressed tile is busy. The requester must then hold `req_valid`, `req_tile` and `req_mode` steady until a cycle where ready is high. A request is taken on the rising edge where both valid and ready are high.

The memory access port has no back-pressure. It is a per-cycle strobe. The block splits the byte address into a tile index (upper bits) and an in-tile offset. It raises the select line of the addressed tile only when that tile is On. Otherwise it flags an error in the same cycle, and the access never reaches the SRAM.

When the parent domain drops, every tile is forced Off. For each tile that was holding data, a flag records that its contents are gone.

Top module: `sram_tile_pwr_ctrl`

## Requirements
- R1: After reset every tile is Off, with both switch enables low, busy low, lost flag low, and `req_ready` high.
- R2: `tile_mode[2i+1:2i]` reports tile i as 0 = Off, 1 = Retention, 2 = On. On drives both enables. Retention drives only the array enable. Off drives neither.
- R3: A tile's peripheral enable is never high while its array enable is low.
- R4: A request to move a tile from Off to On is accepted at edge E0. The array enable is high from E0, busy is high, and the peripheral enable rises at edge E0+settle+1, with settle the value on `settle_cycles` when the request is accepted. Busy then clears.
- R5: On to Off drops the peripheral enable at the accepting edge, with busy high and the mode reported as 1. The array enable drops one edge later. Retention to Off drops the array enable at the accepting edge.
- R6: Retention to On and On to Retention each change the peripheral enable at the accepting edge. The array enable stays high and busy stays low.
- R7: While `parent_on` is low, all tiles are Off from the next edge on. The lost flag of each tile that was not Off is set. Requests that ask for On or Retention then have no effect. A tile's lost flag clears when a power-up request for that tile is accepted.
- R8: The tile index is `acc_addr[ADDR_W-1:17]`. With `acc_valid` high, `sram_sel` is one-hot on that tile if it is On. Otherwise `sram_sel` is zero and `acc_err` is high, in the same cycle. This includes indices of 12 and above. `sram_offset` is `acc_addr[16:0]`.
- R9: `req_ready` is low while the addressed tile is busy, and high for other tiles. A held request takes effect once busy clears.
- R10: A request with mode code 3, with a tile index of 12 or more, or for the mode the tile is already in, changes nothing.
- R11: Off to Retention raises the array enable at the accepting edge. The tile reports Retention after the settle delay, and the peripheral enable stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parent_on | input | 1 | Parent power domain is up |
| settle_cycles | input | 8 | Array settle delay in cycles, sampled when a power-up is accepted |
| req_valid | input | 1 | Mode request valid |
| req_ready | output | 1 | Mode request can be taken |
| req_tile | input | 4 | Target tile index |
| req_mode | input | 2 | Target mode (0 Off, 1 Retention, 2 On, 3 reserved) |
| array_en | output | 12 | Array switch enable per tile |
| periph_en | output | 12 | Peripheral switch enable per tile |
| tile_mode | output | 24 | Settled mode per tile, two bits each |
| tile_busy | output | 12 | Transition in progress per tile |
| tile_lost | output | 12 | Contents lost by parent power-down |
| acc_valid | input | 1 | Memory access strobe |
| acc_addr | input | 21 | Byte address of the access |
| sram_sel | output | 12 | One-hot tile select forwarded to the SRAM |
| sram_offset | output | 17 | Byte offset within the tile |
| acc_err | output | 1 | Access refused (tile not On or index out of range) |

## Verification
The assertions check the switch-ordering rules on every cycle: the peripheral enable never appears without the array enable, rises only after the array was already on, and is gone before a normal array shutdown. They also check that a parent power loss clears the switches, that access selects are one-hot and only reach On tiles, and that requests are refused while the target is busy. The exact settle latency, the lost-flag set and clear rules, and the no-effect cases for reserved codes and out-of-range tiles can only be shown by the bench's directed scenarios.

// File: rtl/sram_pwr_pkg.sv
package sram_pwr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RET  = 2'd1,
    MODE_ON   = 2'd2,
    MODE_RSVD = 2'd3
  } tile_mode_e;

  typedef enum logic [2:0] {
    S_OFF,
    S_SETTLE,
    S_RET,
    S_ON,
    S_DRAIN
  } tile_state_e;
endpackage

// File: rtl/tile_pwr_seq.sv
module tile_pwr_seq
  import sram_pwr_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                parent_on,
  input  logic                req_fire,
  input  tile_mode_e          req_mode,
  input  logic [SETTLE_W-1:0] settle,
  output logic                array_en,
  output logic                periph_en,
  output tile_mode_e          mode_o,
  output logic                busy,
  output logic                lost
);
  tile_state_e         state;
  logic [SETTLE_W-1:0] cnt;
  logic                goal_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_OFF;
      cnt     <= '0;
      goal_on <= 1'b0;
      lost    <= 1'b0;
    end else if (!parent_on) begin
      if (state != S_OFF) lost <= 1'b1;
      state <= S_OFF;
    end else begin
      case (state)
        S_OFF: begin
          if (req_fire && (req_mode == MODE_ON || req_mode == MODE_RET)) begin
            state   <= S_SETTLE;
            cnt     <= settle;
            goal_on <= (req_mode == MODE_ON);
            lost    <= 1'b0;
          end
        end
        S_SETTLE: begin
          if (cnt == '0) state <= goal_on ? S_ON : S_RET;
          else           cnt   <= cnt - 1'b1;
        end
        S_RET: begin
          if (req_fire && req_mode == MODE_ON)       state <= S_ON;
          else if (req_fire && req_mode == MODE_OFF) state <= S_OFF;
        end
        S_ON: begin
          if (req_fire && req_mode == MODE_RET)      state <= S_RET;
          else if (req_fire && req_mode == MODE_OFF) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_OFF;
        default: state <= S_OFF;
      endcase
    end
  end

  always_comb begin
    array_en  = (state != S_OFF);
    periph_en = (state == S_ON);
    busy      = (state == S_SETTLE) || (state == S_DRAIN);
    case (state)
      S_ON:           mode_o = MODE_ON;
      S_RET, S_DRAIN: mode_o = MODE_RET;
      default:        mode_o = MODE_OFF;
    endcase
  end
endmodule

// File: rtl/pwr_req_router.sv
module pwr_req_router #(
  parameter int N_TILES = 12,
  parameter int IDX_W   = 4
) (
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_tile,
  input  logic [N_TILES-1:0] tile_busy,
  output logic               req_ready,
  output logic [N_TILES-1:0] tile_fire
);
  logic busy_sel;

  always_comb begin
    busy_sel = 1'b0;
    for (int i = 0; i < N_TILES; i++) begin
      if (req_tile == IDX_W'(i)) busy_sel = tile_busy[i];
    end
  end

  assign req_ready = !busy_sel;

  for (genvar g = 0; g < N_TILES; g++) begin : g_fire
    assign tile_fire[g] = req_valid && req_ready && (req_tile == IDX_W'(g));
  end
endmodule

// File: rtl/tile_access_gate.sv
module tile_access_gate #(
  parameter int N_TILES = 12,
  parameter int IDX_W   = 4
) (
  input  logic               acc_valid,
  input  logic [IDX_W-1:0]   acc_tile,
  input  logic [N_TILES-1:0] tile_is_on,
  output logic [N_TILES-1:0] sel,
  output logic               err
);
  for (genvar g = 0; g < N_TILES; g++) begin : g_sel
    assign sel[g] = acc_valid && tile_is_on[g] && (acc_tile == IDX_W'(g));
  end

  assign err = acc_valid && !(|sel);
endmodule

// File: rtl/sram_tile_pwr_ctrl.sv
module sram_tile_pwr_ctrl
  import sram_pwr_pkg::*;
#(
  parameter int N_TILES  = 12,
  parameter int TILE_AW  = 17,
  parameter int SETTLE_W = 8,
  localparam int IDX_W   = $clog2(N_TILES),
  localparam int ADDR_W  = IDX_W + TILE_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 parent_on,
  input  logic [SETTLE_W-1:0]  settle_cycles,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [IDX_W-1:0]     req_tile,
  input  logic [1:0]           req_mode,
  output logic [N_TILES-1:0]   array_en,
  output logic [N_TILES-1:0]   periph_en,
  output logic [2*N_TILES-1:0] tile_mode,
  output logic [N_TILES-1:0]   tile_busy,
  output logic [N_TILES-1:0]   tile_lost,
  input  logic                 acc_valid,
  input  logic [ADDR_W-1:0]    acc_addr,
  output logic [N_TILES-1:0]   sram_sel,
  output logic [TILE_AW-1:0]   sram_offset,
  output logic                 acc_err
);
  logic [N_TILES-1:0] tile_fire;
  logic [N_TILES-1:0] tile_is_on;
  tile_mode_e         req_mode_e;

  assign req_mode_e = tile_mode_e'(req_mode);

  pwr_req_router #(.N_TILES(N_TILES), .IDX_W(IDX_W)) u_router (
    .req_valid (req_valid),
    .req_tile  (req_tile),
    .tile_busy (tile_busy),
    .req_ready (req_ready),
    .tile_fire (tile_fire)
  );

  for (genvar g = 0; g < N_TILES; g++) begin : g_tile
    tile_mode_e mode_w;
    tile_pwr_seq #(.SETTLE_W(SETTLE_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .parent_on (parent_on),
      .req_fire  (tile_fire[g]),
      .req_mode  (req_mode_e),
      .settle    (settle_cycles),
      .array_en  (array_en[g]),
      .periph_en (periph_en[g]),
      .mode_o    (mode_w),
      .busy      (tile_busy[g]),
      .lost      (tile_lost[g])
    );
    assign tile_mode[2*g +: 2] = mode_w;
    assign tile_is_on[g]       = (mode_w == MODE_ON);
  end

  tile_access_gate #(.N_TILES(N_TILES), .IDX_W(IDX_W)) u_gate (
    .acc_valid  (acc_valid),
    .acc_tile   (acc_addr[ADDR_W-1:TILE_AW]),
    .tile_is_on (tile_is_on),
    .sel        (sram_sel),
    .err        (acc_err)
  );

  assign sram_offset = acc_addr[TILE_AW-1:0];
endmodule

// File: rtl/sram_tile_pwr_ctrl_chk.sv
module sram_tile_pwr_ctrl_chk #(
  parameter int N_TILES = 12,
  parameter int IDX_W   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 parent_on,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [IDX_W-1:0]     req_tile,
  input logic [N_TILES-1:0]   array_en,
  input logic [N_TILES-1:0]   periph_en,
  input logic [2*N_TILES-1:0] tile_mode,
  input logic [N_TILES-1:0]   tile_busy,
  input logic                 acc_valid,
  input logic [N_TILES-1:0]   sram_sel,
  input logic                 acc_err
);
  for (genvar g = 0; g < N_TILES; g++) begin : g_chk
    p_periph_needs_array_r3: assert property (@(posedge clk) disable iff (!rst_n)
      periph_en[g] |-> array_en[g]);

    p_array_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_en[g]) |-> $past(array_en[g]));

    p_periph_off_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(array_en[g]) && $past(parent_on)) |-> !$past(periph_en[g]));

    p_parent_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !parent_on |=> (!array_en[g] && !periph_en[g]));

    p_sel_only_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sram_sel[g] |-> (tile_mode[2*g +: 2] == 2'd2 && periph_en[g]));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_tile == IDX_W'(g) && tile_busy[g]) |-> !req_ready);
  end

  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sram_sel));

  p_err_or_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_err != (|sram_sel)));
endmodule

bind sram_tile_pwr_ctrl sram_tile_pwr_ctrl_chk #(.N_TILES(N_TILES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .parent_on (parent_on),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_tile  (req_tile),
  .array_en  (array_en),
  .periph_en (periph_en),
  .tile_mode (tile_mode),
  .tile_busy (tile_busy),
  .acc_valid (acc_valid),
  .sram_sel  (sram_sel),
  .acc_err   (acc_err)
);

// File: tb/sram_tile_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module sram_tile_pwr_ctrl_bench;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        parent_on = 1'b1;
  logic [7:0]  settle_cycles = 8'd3;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_tile = '0;
  logic [1:0]  req_mode = '0;
  logic [N-1:0] array_en, periph_en, tile_busy, tile_lost, sram_sel;
  logic [2*N-1:0] tile_mode;
  logic        acc_valid = 1'b0;
  logic [20:0] acc_addr = '0;
  logic [16:0] sram_offset;
  logic        acc_err;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  sram_tile_pwr_ctrl u_sram_tile_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .parent_on(parent_on), .settle_cycles(settle_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_tile(req_tile), .req_mode(req_mode),
    .array_en(array_en), .periph_en(periph_en), .tile_mode(tile_mode),
    .tile_busy(tile_busy), .tile_lost(tile_lost), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .sram_sel(sram_sel), .sram_offset(sram_offset), .acc_err(acc_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(input int t);
    return tile_mode[2*t +: 2];
  endfunction

  task automatic send_req(input int t, input int m);
    req_valid = 1'b1;
    req_tile  = 4'(t);
    req_mode  = 2'(m);
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic access(input int t, input int off);
    acc_valid = 1'b1;
    acc_addr  = 21'((t << 17) | off);
    #1;
  endtask

  task automatic t_reset;
    chk("R1", "array_en", 32'(array_en), 0);
    chk("R1", "periph_en", 32'(periph_en), 0);
    chk("R1", "busy", 32'(tile_busy), 0);
    chk("R1", "lost", 32'(tile_lost), 0);
    chk("R1", "mode", 32'(tile_mode), 0);
    chk("R1", "ready", 32'(req_ready), 1);
  endtask

  task automatic t_power_up;
    settle_cycles = 8'd3;
    send_req(0, 2);
    chk("R4", "array on at accept", 32'(array_en[0]), 1);
    chk("R4", "periph off while settling", 32'(periph_en[0]), 0);
    chk("R4", "busy while settling", 32'(tile_busy[0]), 1);
    chk("R2", "mode off while settling", 32'(mode_of(0)), 0);
    repeat (3) @(negedge clk);
    chk("R4", "periph still off at E0+3", 32'(periph_en[0]), 0);
    @(negedge clk);
    chk("R4", "periph on at E0+4", 32'(periph_en[0]), 1);
    chk("R2", "mode on", 32'(mode_of(0)), 2);
    chk("R4", "busy cleared", 32'(tile_busy[0]), 0);
    chk("R3", "no periph without array", 32'(periph_en & ~array_en), 0);
  endtask

  task automatic t_access;
    access(0, 'h123);
    chk("R8", "sel tile0", 32'(sram_sel), 1);
    chk("R8", "no err tile0", 32'(acc_err), 0);
    chk("R8", "offset", 32'(sram_offset), 'h123);
    access(1, 0);
    chk("R8", "off tile sel", 32'(sram_sel), 0);
    chk("R8", "off tile err", 32'(acc_err), 1);
    access(13, 5);
    chk("R8", "out of range err", 32'(acc_err), 1);
    acc_valid = 1'b0;
    #1;
    chk("R8", "idle no err", 32'(acc_err), 0);
    chk("R8", "idle no sel", 32'(sram_sel), 0);
  endtask

  task automatic t_retention;
    send_req(0, 1);
    chk("R6", "ret mode", 32'(mode_of(0)), 1);
    chk("R6", "ret array", 32'(array_en[0]), 1);
    chk("R6", "ret periph", 32'(periph_en[0]), 0);
    chk("R6", "ret not busy", 32'(tile_busy[0]), 0);
    access(0, 4);
    chk("R8", "ret tile err", 32'(acc_err), 1);
    acc_valid = 1'b0;
    send_req(0, 2);
    chk("R6", "back on mode", 32'(mode_of(0)), 2);
    chk("R6", "back on periph", 32'(periph_en[0]), 1);
  endtask

  task automatic t_off_to_ret;
    settle_cycles = 8'd0;
    send_req(1, 1);
    chk("R11", "array on", 32'(array_en[1]), 1);
    chk("R11", "periph off", 32'(periph_en[1]), 0);
    chk("R11", "busy", 32'(tile_busy[1]), 1);
    @(negedge clk);
    chk("R11", "ret mode", 32'(mode_of(1)), 1);
    chk("R11", "periph still off", 32'(periph_en[1]), 0);
    chk("R11", "busy cleared", 32'(tile_busy[1]), 0);
  endtask

  task automatic t_power_down;
    send_req(0, 0);
    chk("R5", "drain periph off", 32'(periph_en[0]), 0);
    chk("R5", "drain array on", 32'(array_en[0]), 1);
    chk("R5", "drain busy", 32'(tile_busy[0]), 1);
    chk("R5", "drain mode", 32'(mode_of(0)), 1);
    @(negedge clk);
    chk("R5", "array off", 32'(array_en[0]), 0);
    chk("R5", "mode off", 32'(mode_of(0)), 0);
    send_req(1, 0);
    chk("R5", "ret to off array", 32'(array_en[1]), 0);
    chk("R5", "ret to off busy", 32'(tile_busy[1]), 0);
  endtask

  task automatic t_busy_hold;
    settle_cycles = 8'd5;
    send_req(2, 2);
    req_valid = 1'b1; req_tile = 4'd2; req_mode = 2'd1;
    #1;
    chk("R9", "ready low busy tile", 32'(req_ready), 0);
    req_tile = 4'd3;
    #1;
    chk("R9", "ready high other tile", 32'(req_ready), 1);
    req_valid = 1'b0;
    @(negedge clk);
    send_req(2, 1);
    chk("R9", "held request applied", 32'(mode_of(2)), 1);
    chk("R9", "held periph off", 32'(periph_en[2]), 0);
  endtask

  task automatic t_ignored;
    logic [N-1:0] arr_before;
    send_req(2, 3);
    chk("R10", "reserved code", 32'(mode_of(2)), 1);
    arr_before = array_en;
    send_req(12, 2);
    chk("R10", "out of range tile", 32'(array_en), 32'(arr_before));
    send_req(2, 1);
    chk("R10", "same mode", 32'(mode_of(2)), 1);
    chk("R10", "same mode not busy", 32'(tile_busy[2]), 0);
  endtask

  task automatic t_parent_off;
    settle_cycles = 8'd1;
    send_req(4, 2);
    repeat (2) @(negedge clk);
    chk("R7", "tile4 on", 32'(mode_of(4)), 2);
    parent_on = 1'b0;
    @(negedge clk);
    chk("R7", "all array off", 32'(array_en), 0);
    chk("R7", "all periph off", 32'(periph_en), 0);
    chk("R7", "lost flags", 32'(tile_lost), 32'h14);
    send_req(5, 2);
    chk("R7", "power-up ignored", 32'(array_en[5]), 0);
    parent_on = 1'b1;
    @(negedge clk);
    send_req(4, 1);
    chk("R7", "lost cleared tile4", 32'(tile_lost[4]), 0);
    chk("R7", "lost kept tile2", 32'(tile_lost[2]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_up();
    t_access();
    t_retention();
    t_off_to_ret();
    t_power_down();
    t_busy_hold();
    t_ignored();
    t_parent_off();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule